// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Mask Unit

This unit decides, lane by lane, whether each byte of a 32-bit SDRAM data bus takes part in the current beat. The bus is split into four 8-bit lanes, and each lane has its own mask input. Bit `n` of the mask covers data bits `8n` to `8n+7`.

The two directions handle the mask differently. For writes, the mask acts in the same cycle. A high mask bit drops that lane's byte write enable at once, so a single byte can be left untouched inside a wider word. For reads, the mask is sampled on the rising edge and moves through a two-stage pipeline beside a read-beat valid bit. The lane's output enable falls two cycles after the mask was sampled, which puts that byte of the bus in high impedance.

A suspend input freezes the read pipeline and blocks every write strobe while it is high. The array and the bus drivers sit outside this block. They take `rd_oe` and `wr_be` as their controls.

Top module: `sdram_lane_mask`

## Requirements
- R1: Lane n (data bits 8n..8n+7) is governed only by mask bit n. `wr_be[n]` and `rd_oe[n]` never depend on another lane's mask bit.
- R2: The read path uses only the mask value present at a rising edge. A mask pulse that starts and ends between two edges has no effect on `rd_oe`.
- R3: If `rd_active` is high at rising edge k, and suspend is low at edges k and k+1, then during the clock period after edge k+1, `rd_oe[n]` equals the inverse of mask bit n sampled at edge k. A high mask therefore reaches Hi-Z two cycles after sampling, and not before.
- R4: If `rd_active` is low at edge k, then under the same conditions as R3, `rd_oe` is 0000 in the period after edge k+1.
- R5: `wr_be[n]` is `wr_active` AND NOT `mask[n]`, combinationally, in the same cycle, with zero latency.
- R6: While `suspend` is high, `wr_be` is 0000 whatever the state of `wr_active` and `mask`.
- R7: A rising edge with `suspend` high leaves the read pipeline unchanged. `rd_oe` holds its value, and when suspend clears, the stalled beats come out in their original order.
- R8: While `rst_n` is low (asynchronous, active low), the pipeline is cleared and `rd_oe` is 0000. After release, `rd_oe` stays 0000 until a read beat has passed two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_active | input | 1 | A read beat is issued this cycle |
| wr_active | input | 1 | A write beat is issued this cycle |
| mask | input | LANES | Per-lane byte mask, bit n for data bits 8n..8n+7 |
| suspend | input | 1 | Freezes the read pipeline and blocks writes |
| rd_oe | output | LANES | Per-lane output-drive enable for read data |
| wr_be | output | LANES | Per-lane byte write enable |

## Verification
On every cycle the checker confirms four things:
- the write strobes never open a masked lane;
- the write strobes stay shut under suspend or with no write beat;
- the read enables match the masked read flag from two edges earlier, whenever no suspend came in between;
- a suspended edge leaves the read enables unchanged.

Other behaviours are shown only by the bench's scenarios. These are the ordered release of beats held over a multi-cycle suspend, a mask pulse between edges being ignored, and the one-hot lane walk that proves each strobe follows its own mask bit. Also covered there are the asynchronous clear in the middle of a burst and the refill that follows it.

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask #(
  parameter int LANES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_active,
  input  logic             wr_active,
  input  logic [LANES-1:0] mask,
  input  logic             suspend,
  output logic [LANES-1:0] rd_oe,
  output logic [LANES-1:0] wr_be
);

  localparam int TOP = RD_LAT - 1;

  logic [TOP:0] beat_sr;
  logic         wr_open;

  assign wr_open = wr_active & ~suspend;

  generate
    if (RD_LAT == 1) begin : g_beat1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        beat_sr <= '0;
        else if (!suspend) beat_sr <= rd_active;
      end
    end else begin : g_beatn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        beat_sr <= '0;
        else if (!suspend) beat_sr <= {beat_sr[TOP-1:0], rd_active};
      end
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [TOP:0] hide_sr;

      if (RD_LAT == 1) begin : g_sr1
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        hide_sr <= '0;
          else if (!suspend) hide_sr <= mask[g];
        end
      end else begin : g_srn
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        hide_sr <= '0;
          else if (!suspend) hide_sr <= {hide_sr[TOP-1:0], mask[g]};
        end
      end

      assign rd_oe[g] = beat_sr[TOP] & ~hide_sr[TOP];
      assign wr_be[g] = wr_open & ~mask[g];
    end
  endgenerate

endmodule

// File: rtl/sdram_lane_mask_chk.sv
module sdram_lane_mask_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_active,
  input logic             wr_active,
  input logic [LANES-1:0] mask,
  input logic             suspend,
  input logic [LANES-1:0] rd_oe,
  input logic [LANES-1:0] wr_be
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_WR_MASKED_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & wr_be) == '0); // R5

  AST_WR_IDLE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_active |-> wr_be == '0); // R5

  AST_WR_SUSPEND_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> wr_be == '0); // R6

  AST_RD_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(suspend) && !$past(suspend, 2)) |->
      rd_oe == $past({LANES{rd_active}} & ~mask, 2)); // R3

  AST_RD_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(suspend)) |-> $stable(rd_oe)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (rst_n && $past(!rst_n)) |-> rd_oe == '0); // R8

endmodule

bind sdram_lane_mask sdram_lane_mask_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .wr_active(wr_active),
  .mask(mask), .suspend(suspend), .rd_oe(rd_oe), .wr_be(wr_be)
);

// File: tb/sdram_lane_mask_test.sv
`timescale 1ns/1ps
module sdram_lane_mask_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_active = 1'b0;
  logic       wr_active = 1'b0;
  logic [3:0] mask = '0;
  logic       suspend = 1'b0;
  logic [3:0] rd_oe, wr_be;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sdram_lane_mask #(.LANES(4), .RD_LAT(2)) uut (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .wr_active(wr_active),
    .mask(mask), .suspend(suspend), .rd_oe(rd_oe), .wr_be(wr_be)
  );

  // {rd, wr, susp, mask[3:0], expected wr_be, expected rd_oe before this edge}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    15'b1_0_0_0000_0000_0000,
    15'b1_0_0_0101_0000_0000,
    15'b1_0_0_1000_0000_1111,
    15'b0_1_0_0011_1100_1010,
    15'b0_1_0_0000_1111_0111,
    15'b1_1_0_0001_1110_0000,
    15'b1_0_0_0110_0000_0000,
    15'b1_1_1_0000_0000_1110,
    15'b0_1_1_1010_0000_1110,
    15'b0_1_0_0001_1110_1110,
    15'b0_0_0_0000_0000_1001,
    15'b1_0_0_0000_0000_0000
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset clears rd_oe", rd_oe, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rd_active, wr_active, suspend, mask} = VEC[i][14:8];
      #1;
      chk(suspend ? "R6 wr_be under suspend" : "R5 wr_be same-cycle", wr_be, VEC[i][7:4]);
      if (i >= 7 && i <= 10)      chk("R7 read pipeline freeze", rd_oe, VEC[i][3:0]);
      else if (VEC[i][3:0] == '0) chk("R4 no read beat gives no enable", rd_oe, VEC[i][3:0]);
      else                        chk("R3 read mask two-cycle latency", rd_oe, VEC[i][3:0]);
    end

    // R1: one-hot lane walk on the write strobes
    @(negedge clk);
    rd_active = 1'b0; suspend = 1'b0; wr_active = 1'b1;
    for (int n = 0; n < 4; n++) begin
      mask = ~(4'b0001 << n);
      #1;
      chk("R1 lane follows own mask bit", wr_be, 4'b0001 << n);
    end

    // R2: a mask pulse between edges is ignored by the read path
    @(negedge clk);
    wr_active = 1'b0; rd_active = 1'b1; mask = 4'b0000;
    @(posedge clk);
    #1 mask = 4'b1111;
    #2 mask = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    chk("R2 between-edge mask pulse ignored", rd_oe, 4'b1111);

    // R8: asynchronous clear mid-burst, then refill
    rst_n = 1'b0;
    #1;
    chk("R8 async clear mid-burst", rd_oe, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 stays clear one edge after release", rd_oe, 4'b0000);
    @(negedge clk);
    chk("R3 refill after reset", rd_oe, 4'b1111);

    finish_run();
  end

endmodule